// File: doc/BRIEF.md
# Transfer Negotiation Message Unit

This block prepares and interprets the extended messages an initiator uses to agree on synchronous transfer timing and on bus width with each target. It keeps a sixteen-entry settings table, one entry per target on each of two channels, that holds a wide flag, a three-bit rate index and a four-bit offset. Each table entry is indexed by the channel bit above the three-bit target ID. On request it writes either a width request or a synchronous request into an outgoing message buffer, always choosing width first when both are needed. It also tracks per target which negotiation it started.

On the receive side the already-collected bytes of an incoming extended message (length, code and up to two argument bytes) are presented in one cycle. The block classifies the message, reports the agreed period, offset or width, and decides whether to accept it, answer it with a reply message, or refuse it with a reject message. ATN is raised whenever an outgoing reply or reject is waiting. A reject received from the target while a negotiation is pending drops that target to 8-bit or asynchronous settings. Byte-level bus handshaking lies outside the block.

Every operation is registered: results appear one clock after the request, together with a one-cycle `done` strobe, and are held until the next operation.

Top module: `nego_msg_unit`

## Requirements
- R1: A settings write (`cfg_we`) stores `cfg_data` at `cfg_idx`, where bit 7 is the wide flag, bits [6:4] the rate index and bits [3:0] the offset. Operations on channel `c`, target `t` use entry `8*c + t`.
- R2: A width request is the four bytes 0x01, 0x02, 0x03, W (length 4), where W is 0x01 when the entry's wide flag is set and 0x00 otherwise.
- R3: A build with both `bld_need_wide` and `bld_need_sync` produces only the width request.
- R4: A synchronous request is the five bytes 0x01, 0x03, 0x01, period, offset (length 5), where period = 24 + 6 × rate index.
- R5: With `bld_max_ofs` set, the requested offset is 8 if the entry's wide flag is set and 15 otherwise. With `bld_max_ofs` clear, it is the entry's offset nibble.
- R6: A build needing neither message gives `done` with length 0, action NONE and no ATN. The `action` encoding is 0 NONE, 1 ACCEPT, 2 REPLY, 3 REJECT.
- R7: A received extended message is refused if its code is not 1 or 3, if code 1 does not come with length 3, or if code 3 does not come with length 2. Refusal means action REJECT, a one-byte buffer holding 0x07, and ATN high.
- R8: A received synchronous message answering a request this block sent is accepted: action ACCEPT, length 0, no ATN, and `neg_period`/`neg_offset` set to the received bytes. The pending mark is cleared, so an identical second message is handled as unsolicited.
- R9: A received synchronous message whose period is below 24 is refused as in R7.
- R10: An unsolicited synchronous message with a period of 24 or more gets a reply with the received period and the offset min(received, 8 if wide else 15), with ATN and action REPLY. The agreed period and offset are reported.
- R11: A received width message answering a pending width request is accepted with `neg_wide` = (width byte is 0x01). An unsolicited one gets a width reply whose W is 0x01 only if the byte is 0x01 and the entry's wide flag is set, with ATN.
- R12: `rx_rej` with a width request pending clears that entry's wide flag. Otherwise, with a synchronous request pending, it clears the rate and offset fields. It produces no `done`.
- R13: `msg_len` never exceeds the buffer depth, and `done` is high only in the cycle after an `rx_valid` or `bld_req`.
- R14: After reset, `done`, `atn`, `action` and `msg_len` are 0 and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings table write strobe |
| cfg_idx | input | 4 | Settings entry to write |
| cfg_data | input | 8 | Settings value {wide, rate[2:0], offset[3:0]} |
| bld_req | input | 1 | Build a self-initiated message |
| bld_chan | input | 1 | Channel of the target to build for |
| bld_tgt | input | 3 | Target ID to build for |
| bld_need_wide | input | 1 | Width negotiation wanted |
| bld_need_sync | input | 1 | Synchronous negotiation wanted |
| bld_max_ofs | input | 1 | Request the largest offset the width allows |
| rx_valid | input | 1 | A received extended message is presented |
| rx_rej | input | 1 | A message reject was received from the target |
| rx_chan | input | 1 | Channel of the received message |
| rx_tgt | input | 3 | Target ID of the received message |
| rx_len | input | 8 | Received extended length byte |
| rx_code | input | 8 | Received extended code byte |
| rx_arg0 | input | 8 | First argument (period or width) |
| rx_arg1 | input | 8 | Second argument (offset) |
| done | output | 1 | One-cycle result strobe |
| action | output | 2 | 0 none, 1 accept, 2 reply, 3 reject |
| atn | output | 1 | Request to raise ATN for the buffered message |
| msg_len | output | 4 | Number of valid bytes in the buffer |
| msg_bytes | output | 64 | Message buffer, byte i at bits [8i+7:8i] |
| neg_period | output | 8 | Agreed transfer period |
| neg_offset | output | 8 | Agreed offset |
| neg_wide | output | 1 | Agreed 16-bit width |

## Verification
On every cycle the assertions check the relations that never depend on history. The buffer length stays within its depth. `done` only follows a request. ATN only accompanies a reply or a refusal. Every refusal holds the single reject byte. An acceptance leaves the buffer empty with ATN low. Every five-byte buffer carries the synchronous header. A combined width-and-sync build yields the width message. The remaining behaviours depend on table contents and on which negotiation is pending for which target, and only the bench's scenarios show them. These are the period arithmetic, the offset limits, the switch from accept to reply once a pending mark is used up, and the fallback after a target rejects.

// File: rtl/nego_pkg.sv
package nego_pkg;

    localparam logic [7:0] EXT_LEAD    = 8'h01;
    localparam logic [7:0] CODE_SYNC   = 8'h01;
    localparam logic [7:0] CODE_WIDTH  = 8'h03;
    localparam logic [7:0] LEN_SYNC    = 8'h03;
    localparam logic [7:0] LEN_WIDTH   = 8'h02;
    localparam logic [7:0] REJECT_BYTE = 8'h07;
    localparam logic [7:0] PERIOD_BASE = 8'd24;
    localparam logic [7:0] PERIOD_STEP = 8'd6;
    localparam logic [7:0] OFS_CAP_8   = 8'd15;
    localparam logic [7:0] OFS_CAP_16  = 8'd8;

    typedef struct packed {
        logic       wide;
        logic [2:0] rate;
        logic [3:0] ofs;
    } tgt_cfg_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ACCEPT = 2'd1,
        ACT_REPLY  = 2'd2,
        ACT_REJECT = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        MK_NONE  = 2'd0,
        MK_WIDTH = 2'd1,
        MK_SYNC  = 2'd2,
        MK_REJ   = 2'd3
    } mk_e;

    typedef struct packed {
        mk_e        kind;
        logic [7:0] period;
        logic [7:0] offset;
        logic       wide16;
    } mk_req_t;

    function automatic logic [7:0] period_of(input logic [2:0] rate);
        return PERIOD_BASE + PERIOD_STEP * {5'd0, rate};
    endfunction

    function automatic logic [7:0] ofs_cap(input logic wide);
        return wide ? OFS_CAP_16 : OFS_CAP_8;
    endfunction

    function automatic logic [7:0] min8(input logic [7:0] a, input logic [7:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/nego_cfg_table.sv
module nego_cfg_table
    import nego_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tgt_cfg_t         wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             drop_wide,
    input  logic             drop_sync,
    output tgt_cfg_t         rd_data
);

    tgt_cfg_t entry_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                entry_q[g] <= wr_data;
            end else if (rd_idx == IDX_W'(g)) begin
                if (drop_wide) begin
                    entry_q[g].wide <= 1'b0;
                end else if (drop_sync) begin
                    entry_q[g].rate <= '0;
                    entry_q[g].ofs  <= '0;
                end
            end
        end
    end

    assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/nego_pend_track.sv
module nego_pend_track #(
    parameter int IDX_W   = 4,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             set_w,
    input  logic             set_s,
    input  logic             clr_w,
    input  logic             clr_s,
    output logic             pend_w,
    output logic             pend_s
);

    logic [ENTRIES-1:0] wide_q;
    logic [ENTRIES-1:0] sync_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                wide_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else if (idx == IDX_W'(g)) begin
                if (set_w)      wide_q[g] <= 1'b1;
                else if (clr_w) wide_q[g] <= 1'b0;
                if (set_s)      sync_q[g] <= 1'b1;
                else if (clr_s) sync_q[g] <= 1'b0;
            end
        end
    end

    assign pend_w = wide_q[idx];
    assign pend_s = sync_q[idx];

endmodule

// File: rtl/nego_rx_classify.sv
module nego_rx_classify
    import nego_pkg::*;
#(
    parameter int MIN_PERIOD = 24
) (
    input  logic [7:0] rx_len,
    input  logic [7:0] rx_code,
    input  logic [7:0] rx_arg0,
    input  logic [7:0] rx_arg1,
    input  logic       tgt_wide,
    input  logic       pend_w,
    input  logic       pend_s,
    output act_e       act,
    output mk_req_t    mk,
    output logic       clr_w,
    output logic       clr_s,
    output logic       upd_sync,
    output logic       upd_wide,
    output logic [7:0] got_period,
    output logic [7:0] got_offset,
    output logic       got_wide
);

    localparam logic [7:0] MIN_P = 8'(MIN_PERIOD);

    logic is_sync;
    logic is_width;
    logic [7:0] lim_ofs;

    assign is_sync  = (rx_code == CODE_SYNC)  && (rx_len == LEN_SYNC);
    assign is_width = (rx_code == CODE_WIDTH) && (rx_len == LEN_WIDTH);
    assign lim_ofs  = min8(rx_arg1, ofs_cap(tgt_wide));

    always_comb begin
        act        = ACT_REJECT;
        mk         = '{kind: MK_REJ, period: 8'd0, offset: 8'd0, wide16: 1'b0};
        clr_w      = 1'b0;
        clr_s      = 1'b0;
        upd_sync   = 1'b0;
        upd_wide   = 1'b0;
        got_period = rx_arg0;
        got_offset = rx_arg1;
        got_wide   = 1'b0;
        if (is_sync) begin
            clr_s = pend_s;
            if (rx_arg0 < MIN_P) begin
                act = ACT_REJECT;
            end else if (pend_s) begin
                act      = ACT_ACCEPT;
                mk.kind  = MK_NONE;
                upd_sync = 1'b1;
            end else begin
                act        = ACT_REPLY;
                mk         = '{kind: MK_SYNC, period: rx_arg0, offset: lim_ofs, wide16: 1'b0};
                upd_sync   = 1'b1;
                got_offset = lim_ofs;
            end
        end else if (is_width) begin
            upd_wide = 1'b1;
            if (pend_w) begin
                act      = ACT_ACCEPT;
                mk.kind  = MK_NONE;
                clr_w    = 1'b1;
                got_wide = (rx_arg0 == 8'h01);
            end else begin
                act      = ACT_REPLY;
                got_wide = (rx_arg0 == 8'h01) && tgt_wide;
                mk       = '{kind: MK_WIDTH, period: 8'd0, offset: 8'd0, wide16: got_wide};
            end
        end
    end

endmodule

// File: rtl/nego_msg_compose.sv
module nego_msg_compose
    import nego_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    localparam int LEN_W    = $clog2(BUF_DEPTH + 1)
) (
    input  mk_req_t                  req,
    output logic [8*BUF_DEPTH-1:0]   bytes,
    output logic [LEN_W-1:0]         len
);

    localparam int RAW_N = 5;

    logic [7:0] raw [RAW_N];
    logic [2:0] raw_n;

    always_comb begin
        for (int i = 0; i < RAW_N; i++) raw[i] = 8'h00;
        raw_n = 3'd0;
        case (req.kind)
            MK_WIDTH: begin
                raw[0] = EXT_LEAD;
                raw[1] = LEN_WIDTH;
                raw[2] = CODE_WIDTH;
                raw[3] = {7'd0, req.wide16};
                raw_n  = 3'd4;
            end
            MK_SYNC: begin
                raw[0] = EXT_LEAD;
                raw[1] = LEN_SYNC;
                raw[2] = CODE_SYNC;
                raw[3] = req.period;
                raw[4] = req.offset;
                raw_n  = 3'd5;
            end
            MK_REJ: begin
                raw[0] = REJECT_BYTE;
                raw_n  = 3'd1;
            end
            default: raw_n = 3'd0;
        endcase
    end

    always_comb begin
        bytes = '0;
        for (int i = 0; i < BUF_DEPTH; i++) begin
            if (i < RAW_N && i < int'(raw_n)) bytes[8*i +: 8] = raw[i];
        end
        len = (int'(raw_n) > BUF_DEPTH) ? LEN_W'(BUF_DEPTH) : LEN_W'(raw_n);
    end

endmodule

// File: rtl/nego_msg_unit.sv
module nego_msg_unit
    import nego_pkg::*;
#(
    parameter int TGT_W      = 3,
    parameter int BUF_DEPTH  = 8,
    parameter int MIN_PERIOD = 24,
    localparam int IDX_W     = TGT_W + 1,
    localparam int ENTRIES   = 1 << IDX_W,
    localparam int LEN_W     = $clog2(BUF_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [7:0]             cfg_data,
    input  logic                   bld_req,
    input  logic                   bld_chan,
    input  logic [TGT_W-1:0]       bld_tgt,
    input  logic                   bld_need_wide,
    input  logic                   bld_need_sync,
    input  logic                   bld_max_ofs,
    input  logic                   rx_valid,
    input  logic                   rx_rej,
    input  logic                   rx_chan,
    input  logic [TGT_W-1:0]       rx_tgt,
    input  logic [7:0]             rx_len,
    input  logic [7:0]             rx_code,
    input  logic [7:0]             rx_arg0,
    input  logic [7:0]             rx_arg1,
    output logic                   done,
    output logic [1:0]             action,
    output logic                   atn,
    output logic [LEN_W-1:0]       msg_len,
    output logic [8*BUF_DEPTH-1:0] msg_bytes,
    output logic [7:0]             neg_period,
    output logic [7:0]             neg_offset,
    output logic                   neg_wide
);

    // Operation selection: received message, then target reject, then build.
    logic             do_rx, do_rej, do_bld;
    logic [IDX_W-1:0] op_idx;

    assign do_rx  = rx_valid;
    assign do_rej = rx_rej && !rx_valid;
    assign do_bld = bld_req && !rx_valid && !rx_rej;
    assign op_idx = (rx_valid || rx_rej) ? {rx_chan, rx_tgt} : {bld_chan, bld_tgt};

    tgt_cfg_t cur_cfg;
    logic     pend_w, pend_s;
    logic     drop_wide, drop_sync;

    // Receive classification.
    act_e       rx_act;
    mk_req_t    rx_mk;
    logic       rx_clr_w, rx_clr_s, rx_upd_sync, rx_upd_wide;
    logic [7:0] rx_period, rx_offset;
    logic       rx_wide;

    nego_rx_classify #(.MIN_PERIOD(MIN_PERIOD)) u_classify (
        .rx_len     (rx_len),
        .rx_code    (rx_code),
        .rx_arg0    (rx_arg0),
        .rx_arg1    (rx_arg1),
        .tgt_wide   (cur_cfg.wide),
        .pend_w     (pend_w),
        .pend_s     (pend_s),
        .act        (rx_act),
        .mk         (rx_mk),
        .clr_w      (rx_clr_w),
        .clr_s      (rx_clr_s),
        .upd_sync   (rx_upd_sync),
        .upd_wide   (rx_upd_wide),
        .got_period (rx_period),
        .got_offset (rx_offset),
        .got_wide   (rx_wide)
    );

    // Self-initiated build: width first, one message per command.
    mk_req_t bld_mk;

    always_comb begin
        bld_mk.period = period_of(cur_cfg.rate);
        bld_mk.offset = bld_max_ofs ? ofs_cap(cur_cfg.wide) : {4'd0, cur_cfg.ofs};
        bld_mk.wide16 = cur_cfg.wide;
        if (bld_need_wide)      bld_mk.kind = MK_WIDTH;
        else if (bld_need_sync) bld_mk.kind = MK_SYNC;
        else                    bld_mk.kind = MK_NONE;
    end

    // Pending-negotiation bookkeeping per target.
    logic set_w, set_s, clr_w, clr_s;

    assign set_w     = do_bld && (bld_mk.kind == MK_WIDTH);
    assign set_s     = do_bld && (bld_mk.kind == MK_SYNC);
    assign drop_wide = do_rej && pend_w;
    assign drop_sync = do_rej && !pend_w && pend_s;
    assign clr_w     = (do_rx && rx_clr_w) || drop_wide;
    assign clr_s     = (do_rx && rx_clr_s) || drop_sync;

    nego_pend_track #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .idx    (op_idx),
        .set_w  (set_w),
        .set_s  (set_s),
        .clr_w  (clr_w),
        .clr_s  (clr_s),
        .pend_w (pend_w),
        .pend_s (pend_s)
    );

    nego_cfg_table #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_data   (tgt_cfg_t'(cfg_data)),
        .rd_idx    (op_idx),
        .drop_wide (drop_wide),
        .drop_sync (drop_sync),
        .rd_data   (cur_cfg)
    );

    // Message composition.
    mk_req_t                  sel_mk;
    logic [8*BUF_DEPTH-1:0]   cmp_bytes;
    logic [LEN_W-1:0]         cmp_len;

    assign sel_mk = do_rx ? rx_mk : bld_mk;

    nego_msg_compose #(.BUF_DEPTH(BUF_DEPTH)) u_compose (
        .req   (sel_mk),
        .bytes (cmp_bytes),
        .len   (cmp_len)
    );

    // Result registers.
    act_e next_act;
    assign next_act = do_rx ? rx_act : ACT_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            action     <= ACT_NONE;
            atn        <= 1'b0;
            msg_len    <= '0;
            msg_bytes  <= '0;
            neg_period <= '0;
            neg_offset <= '0;
            neg_wide   <= 1'b0;
        end else begin
            done <= do_rx || do_bld;
            atn  <= 1'b0;
            if (do_rx || do_bld) begin
                action    <= next_act;
                atn       <= (next_act == ACT_REPLY) || (next_act == ACT_REJECT);
                msg_len   <= cmp_len;
                msg_bytes <= cmp_bytes;
            end
            if (do_rx && rx_upd_sync && rx_act != ACT_REJECT) begin
                neg_period <= rx_period;
                neg_offset <= rx_offset;
            end
            if (do_rx && rx_upd_wide) begin
                neg_wide <= rx_wide;
            end
        end
    end

endmodule

// File: rtl/nego_msg_unit_chk.sv
module nego_msg_unit_chk #(
    parameter int BUF_DEPTH = 8,
    localparam int LEN_W    = $clog2(BUF_DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bld_req,
    input logic                   bld_need_wide,
    input logic                   rx_valid,
    input logic                   rx_rej,
    input logic                   done,
    input logic [1:0]             action,
    input logic                   atn,
    input logic [LEN_W-1:0]       msg_len,
    input logic [8*BUF_DEPTH-1:0] msg_bytes
);

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (rst)
        msg_len <= LEN_W'(BUF_DEPTH));

    assert_done_follows_op_R13: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rx_valid || bld_req));

    assert_atn_with_reply_R7: assert property (@(posedge clk) disable iff (rst)
        atn |-> (done && (action == 2'd2 || action == 2'd3)));

    assert_reject_form_R7: assert property (@(posedge clk) disable iff (rst)
        (done && action == 2'd3) |-> (msg_len == LEN_W'(1) && msg_bytes[7:0] == 8'h07));

    assert_accept_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (done && action == 2'd1) |-> (!atn && msg_len == '0));

    assert_sync_header_R4: assert property (@(posedge clk) disable iff (rst)
        (done && msg_len == LEN_W'(5)) |->
            (msg_bytes[7:0] == 8'h01 && msg_bytes[15:8] == 8'h03 && msg_bytes[23:16] == 8'h01));

    assert_wide_first_R3: assert property (@(posedge clk) disable iff (rst)
        (done && $past(bld_req && bld_need_wide && !rx_valid && !rx_rej)) |->
            (msg_len == LEN_W'(4) && msg_bytes[23:16] == 8'h03));

endmodule

bind nego_msg_unit nego_msg_unit_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bld_req       (bld_req),
    .bld_need_wide (bld_need_wide),
    .rx_valid      (rx_valid),
    .rx_rej        (rx_rej),
    .done          (done),
    .action        (action),
    .atn           (atn),
    .msg_len       (msg_len),
    .msg_bytes     (msg_bytes)
);

// File: tb/nego_msg_unit_tb_top.sv
module nego_msg_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_data = '0;
    logic        bld_req = 1'b0, bld_chan = 1'b0;
    logic [2:0]  bld_tgt = '0;
    logic        bld_need_wide = 1'b0, bld_need_sync = 1'b0, bld_max_ofs = 1'b0;
    logic        rx_valid = 1'b0, rx_rej = 1'b0, rx_chan = 1'b0;
    logic [2:0]  rx_tgt = '0;
    logic [7:0]  rx_len = '0, rx_code = '0, rx_arg0 = '0, rx_arg1 = '0;
    logic        done, atn, neg_wide;
    logic [1:0]  action;
    logic [3:0]  msg_len;
    logic [63:0] msg_bytes;
    logic [7:0]  neg_period, neg_offset;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    nego_msg_unit dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .bld_req(bld_req), .bld_chan(bld_chan), .bld_tgt(bld_tgt),
        .bld_need_wide(bld_need_wide), .bld_need_sync(bld_need_sync), .bld_max_ofs(bld_max_ofs),
        .rx_valid(rx_valid), .rx_rej(rx_rej), .rx_chan(rx_chan), .rx_tgt(rx_tgt),
        .rx_len(rx_len), .rx_code(rx_code), .rx_arg0(rx_arg0), .rx_arg1(rx_arg1),
        .done(done), .action(action), .atn(atn), .msg_len(msg_len), .msg_bytes(msg_bytes),
        .neg_period(neg_period), .neg_offset(neg_offset), .neg_wide(neg_wide)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int byte_at(input int i);
        return int'(msg_bytes[8*i +: 8]);
    endfunction

    task automatic check_msg(input string tag, input int n, input int b0, input int b1,
                             input int b2, input int b3, input int b4);
        int exp_b [5];
        exp_b = '{b0, b1, b2, b3, b4};
        check({tag, " len"}, int'(msg_len), n);
        for (int i = 0; i < n; i++) check({tag, " byte"}, byte_at(i), exp_b[i]);
    endtask

    task automatic check_result(input string tag, input int act, input int a);
        check({tag, " done"}, int'(done), 1);
        check({tag, " action"}, int'(action), act);
        check({tag, " atn"}, int'(atn), a);
    endtask

    task automatic do_cfg(input int idx, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_build(input int ch, input int tg, input bit w, input bit s, input bit m);
        @(negedge clk);
        bld_req = 1'b1; bld_chan = ch[0]; bld_tgt = 3'(tg);
        bld_need_wide = w; bld_need_sync = s; bld_max_ofs = m;
        @(negedge clk);
        bld_req = 1'b0;
    endtask

    task automatic do_rx(input int ch, input int tg, input int ln, input int cd,
                         input int a0, input int a1);
        @(negedge clk);
        rx_valid = 1'b1; rx_chan = ch[0]; rx_tgt = 3'(tg);
        rx_len = 8'(ln); rx_code = 8'(cd); rx_arg0 = 8'(a0); rx_arg1 = 8'(a1);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_rej(input int ch, input int tg);
        @(negedge clk);
        rx_rej = 1'b1; rx_chan = ch[0]; rx_tgt = 3'(tg);
        @(negedge clk);
        rx_rej = 1'b0;
    endtask

    task automatic t_reset;
        check("R14 done", int'(done), 0);
        check("R14 atn", int'(atn), 0);
        check("R14 action", int'(action), 0);
        check("R14 len", int'(msg_len), 0);
        do_build(0, 1, 0, 1, 0);
        check_msg("R14 cleared table", 5, 1, 3, 1, 24, 0);
    endtask

    task automatic t_sync_build;
        do_cfg(12, 8'h25);
        do_cfg(5, 8'h83);
        do_cfg(3, 8'h80);
        do_cfg(0, 8'h70);
        do_build(1, 4, 0, 1, 0);
        check_result("R1 R4 sync build", 0, 0);
        check_msg("R1 R4 R5 chan1 tgt4", 5, 1, 3, 1, 36, 5);
        do_build(1, 4, 0, 1, 1);
        check_msg("R5 max ofs narrow", 5, 1, 3, 1, 36, 15);
        do_build(0, 0, 0, 1, 0);
        check_msg("R4 top rate", 5, 1, 3, 1, 66, 0);
    endtask

    task automatic t_wide_first;
        do_build(0, 5, 1, 1, 1);
        check_msg("R3 R2 both needed", 4, 1, 2, 3, 1, 0);
        do_build(1, 4, 1, 0, 0);
        check_msg("R2 narrow width", 4, 1, 2, 3, 0, 0);
        do_build(0, 5, 0, 1, 1);
        check_msg("R5 max ofs wide", 5, 1, 3, 1, 24, 8);
    endtask

    task automatic t_empty_build;
        do_build(0, 2, 0, 0, 0);
        check_result("R6 empty", 0, 0);
        check("R6 len", int'(msg_len), 0);
    endtask

    task automatic t_bad_ext;
        do_rx(0, 2, 2, 1, 40, 4);
        check_result("R7 sync bad len", 3, 1);
        check_msg("R7 sync bad len", 1, 7, 0, 0, 0, 0);
        do_rx(0, 2, 3, 3, 1, 0);
        check_result("R7 width bad len", 3, 1);
        do_rx(0, 2, 3, 5, 0, 0);
        check_result("R7 unknown code", 3, 1);
        check_msg("R7 unknown code", 1, 7, 0, 0, 0, 0);
    endtask

    task automatic t_sync_rx;
        do_rx(1, 4, 3, 1, 50, 7);
        check_result("R8 accept", 1, 0);
        check("R8 len", int'(msg_len), 0);
        check("R8 period", int'(neg_period), 50);
        check("R8 offset", int'(neg_offset), 7);
        do_rx(1, 4, 3, 1, 50, 7);
        check_result("R8 R10 second is reply", 2, 1);
        check_msg("R10 reply", 5, 1, 3, 1, 50, 7);
        do_rx(0, 2, 3, 1, 40, 20);
        check_msg("R10 cap narrow", 5, 1, 3, 1, 40, 15);
        check("R10 neg offset", int'(neg_offset), 15);
        do_rx(0, 3, 3, 1, 40, 12);
        check_msg("R10 cap wide", 5, 1, 3, 1, 40, 8);
    endtask

    task automatic t_short_period;
        do_rx(0, 2, 3, 1, 20, 4);
        check_result("R9 short period", 3, 1);
        check_msg("R9 short period", 1, 7, 0, 0, 0, 0);
        do_rx(0, 2, 3, 1, 24, 4);
        check_result("R9 boundary ok", 2, 1);
        check_msg("R9 boundary ok", 5, 1, 3, 1, 24, 4);
    endtask

    task automatic t_width_rx;
        do_rx(0, 5, 2, 3, 1, 0);
        check_result("R11 accept", 1, 0);
        check("R11 neg wide", int'(neg_wide), 1);
        do_rx(0, 5, 2, 3, 1, 0);
        check_result("R11 unsolicited", 2, 1);
        check_msg("R11 reply wide", 4, 1, 2, 3, 1, 0);
        do_rx(1, 4, 2, 3, 1, 0);
        check_result("R11 accept narrow tgt", 1, 0);
        do_rx(1, 4, 2, 3, 1, 0);
        check_msg("R11 reply narrow", 4, 1, 2, 3, 0, 0);
        check("R11 neg wide narrow", int'(neg_wide), 0);
    endtask

    task automatic t_rej_fallback;
        do_build(0, 5, 1, 0, 0);
        do_rej(0, 5);
        check("R12 no done", int'(done), 0);
        do_build(0, 5, 1, 0, 0);
        check_msg("R12 wide dropped", 4, 1, 2, 3, 0, 0);
        do_build(1, 4, 0, 1, 0);
        do_rej(1, 4);
        do_build(1, 4, 0, 1, 0);
        check_msg("R12 async fallback", 5, 1, 3, 1, 24, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sync_build();
        t_wide_first();
        t_empty_build();
        t_bad_ext();
        t_sync_rx();
        t_short_period();
        t_width_rx();
        t_rej_fallback();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule